// File: doc/BRIEF.md
# Addressing Mode Decoder with Extension Fetch

This block turns the 6-bit mode/register field of a coprocessor instruction into an operand descriptor. The descriptor holds a register number in a 16-entry file, a flag vector that names the operand form, and a 32-bit immediate value. The upper three bits of the field select the mode. The lower three bits select a register, or a sub-mode when the mode is 7.

After the decode, the block reads the extension words that follow the instruction. It uses a 16-bit read port with a request/valid handshake and a fault bit. It packs those words into the immediate value and advances a running instruction-length counter by 2 for each word it accepts. Each word is read at the instruction address plus the current length.

A transaction starts with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, which comes with the final descriptor, the length and a status code. Illegal encodings, fetch faults and immediate operands that are too wide are reported through that status code.

Top module: `amd_ext_decoder`

## Requirements
- R1: Mode 0 (modreg[5:3]=0) gives a register number equal to modreg[2:0] and the direct flag. The flag vector is bit0 direct, bit1 pre-decrement, bit2 post-increment, bit3 offset, bit4 indexed, bit5 absolute, bit6 PC-relative, bit7 immediate. No word is fetched and the length is unchanged.
- R2: Modes 1 to 4 give a register number of 8 plus modreg[2:0] and fetch nothing. The flags are: mode 1 direct, mode 2 none, mode 3 post-increment, mode 4 pre-decrement.
- R3: Mode 5 (offset flag) and mode 6 (indexed flag) give a register number of 8 plus modreg[2:0]. Each fetches one word, which is sign-extended from bit 15 into the immediate.
- R4: In mode 7 the register number is modreg[2:0], and the sub-modes are:
  - 0: absolute, one word, sign-extended.
  - 1: absolute, two words. The immediate is (first<<16)|second.
  - 2: PC-relative with offset, one word.
  - 3: PC-relative and indexed, one word.
  - 4: immediate. The word count follows op_size in bytes: 0 bytes gives none, 1 or 2 bytes gives one word, more gives two words.
- R5: Mode 7 with modreg[2:0] equal to 5, 6 or 7 ends with status 1 (illegal). No fetch is made and the length is unchanged.
- R6: The n-th word (n from 0) is requested at pc+len_in+2n. Each accepted word adds 2 to ins_len.
- R7: A read that returns fault ends the transaction with status 2. No further word is requested, and the faulted word adds nothing to the length.
- R8: fetch_req stays high with a stable fetch_addr until fetch_valid is seen.
- R9: done is high for exactly one cycle per accepted start. Status codes are 0 ok, 1 illegal, 2 fetch fault, 3 unsupported. After reset, done and fetch_req are low.
- R10: An immediate operand wider than 4 bytes reads exactly two words, packs them as in R4, and ends with status 3.
- R11: A start pulse during a transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode; ignored while busy |
| modreg | input | 6 | Mode (bits 5:3) and register (bits 2:0) field |
| op_size | input | SIZE_W | Operand size in bytes |
| pc | input | ADDR_W | Address of the instruction |
| len_in | input | LEN_W | Instruction length before the extension words |
| fetch_req | output | 1 | Extension word read request |
| fetch_addr | output | ADDR_W | Address of the requested word |
| fetch_valid | input | 1 | Read response valid |
| fetch_fault | input | 1 | Read response is a fault |
| fetch_data | input | 16 | Read response word |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code |
| reg_num | output | 4 | Register number in the 16-entry file |
| flags | output | 8 | Operand form flags |
| immed | output | IMM_W | Assembled immediate value |
| ins_len | output | LEN_W | Instruction length after the extension words |

## Verification
The bound checker watches every cycle for these rules:
- `done` never lasts two cycles.
- A pending request holds its address.
- Every request address equals the captured pc plus length plus twice the accepted word count.
- The final length matches the accepted word count.
- An illegal result comes with no fetch.
- No transaction accepts more than two words.

Only the directed scenarios can show the parts that depend on the encoding table. These are the register number and flags for each mode, sign extension and word packing of the immediate, the status chosen for faults and wide immediates, and that a second start during a transaction leaves it untouched.

// File: rtl/amd_pkg.sv
package amd_pkg;
   localparam int FLAG_W = 8;
   localparam int F_DIRECT  = 0;
   localparam int F_PREDEC  = 1;
   localparam int F_POSTINC = 2;
   localparam int F_OFFSET  = 3;
   localparam int F_INDEXED = 4;
   localparam int F_ABS     = 5;
   localparam int F_PCREL   = 6;
   localparam int F_IMMED   = 7;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_ILLEGAL = 2'd1,
      ST_FAULT   = 2'd2,
      ST_UNSUP   = 2'd3
   } amd_status_e;

   typedef struct packed {
      logic [3:0]        regnum;
      logic [FLAG_W-1:0] flags;
      logic [1:0]        words;
      logic              illegal;
      logic              unsup;
   } amd_decode_t;
endpackage

// File: rtl/amd_mode_decode.sv
module amd_mode_decode
   import amd_pkg::*;
#(
   parameter int SIZE_W = 4
) (
   input  logic [5:0]        modreg,
   input  logic [SIZE_W-1:0] op_size,
   output amd_decode_t       dec
);
   localparam logic [SIZE_W-1:0] ONE_WORD_MAX = SIZE_W'(2);
   localparam logic [SIZE_W-1:0] FIT_MAX      = SIZE_W'(4);

   logic [2:0] lo;
   assign lo = modreg[2:0];

   always_comb begin
      dec        = '0;
      dec.regnum = {1'b1, lo};
      case (modreg[5:3])
         3'd0: begin
            dec.regnum          = {1'b0, lo};
            dec.flags[F_DIRECT] = 1'b1;
         end
         3'd1: dec.flags[F_DIRECT]  = 1'b1;
         3'd2: dec.flags            = '0;
         3'd3: dec.flags[F_POSTINC] = 1'b1;
         3'd4: dec.flags[F_PREDEC]  = 1'b1;
         3'd5: begin
            dec.flags[F_OFFSET] = 1'b1;
            dec.words           = 2'd1;
         end
         3'd6: begin
            dec.flags[F_INDEXED] = 1'b1;
            dec.words            = 2'd1;
         end
         default: begin
            dec.regnum = {1'b0, lo};
            case (lo)
               3'd0: begin
                  dec.flags[F_ABS] = 1'b1;
                  dec.words        = 2'd1;
               end
               3'd1: begin
                  dec.flags[F_ABS] = 1'b1;
                  dec.words        = 2'd2;
               end
               3'd2: begin
                  dec.flags[F_PCREL]  = 1'b1;
                  dec.flags[F_OFFSET] = 1'b1;
                  dec.words           = 2'd1;
               end
               3'd3: begin
                  dec.flags[F_PCREL]   = 1'b1;
                  dec.flags[F_INDEXED] = 1'b1;
                  dec.words            = 2'd1;
               end
               3'd4: begin
                  dec.flags[F_IMMED] = 1'b1;
                  if (op_size == '0)
                     dec.words = 2'd0;
                  else if (op_size <= ONE_WORD_MAX)
                     dec.words = 2'd1;
                  else
                     dec.words = 2'd2;
                  dec.unsup = (op_size > FIT_MAX);
               end
               default: dec.illegal = 1'b1;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/amd_ext_assembler.sv
module amd_ext_assembler #(
   parameter int IMM_W    = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take_first,
   input  logic             take_second,
   input  logic [15:0]      word,
   output logic [IMM_W-1:0] imm
);
   localparam int PAD_W = IMM_W - 16;

   logic [PAD_W-1:0] pad;

   generate
      if (SIGN_EXT) begin : g_sext
         assign pad = {PAD_W{word[15]}};
      end else begin : g_zext
         assign pad = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         imm <= '0;
      else if (clear)
         imm <= '0;
      else if (take_first)
         imm <= {pad, word};
      else if (take_second)
         imm <= {imm[IMM_W-17:0], word};
   end
endmodule

// File: rtl/amd_fetch_seq.sv
module amd_fetch_seq
   import amd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [LEN_W-1:0]  len_in,
   input  amd_decode_t       dec,
   input  logic              fetch_valid,
   input  logic              fetch_fault,
   output logic              accept,
   output logic              take_first,
   output logic              take_second,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              done,
   output logic [1:0]        status,
   output logic [LEN_W-1:0]  len_out
);
   typedef enum logic [2:0] {S_IDLE, S_CHECK, S_W1, S_W2, S_DONE} seq_e;

   localparam logic [LEN_W-1:0] STEP = LEN_W'(2);

   seq_e              st;
   logic [ADDR_W-1:0] pc_q;
   amd_status_e       stat_q;
   logic              good_word;
   amd_status_e       end_stat;

   assign accept      = start && (st == S_IDLE);
   assign good_word   = fetch_valid && !fetch_fault;
   assign take_first  = (st == S_W1) && good_word;
   assign take_second = (st == S_W2) && good_word;
   assign fetch_req   = (st == S_W1) || (st == S_W2);
   assign fetch_addr  = pc_q + ADDR_W'(len_out);
   assign done        = (st == S_DONE);
   assign status      = stat_q;
   assign end_stat    = dec.unsup ? ST_UNSUP : ST_OK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         pc_q    <= '0;
         len_out <= '0;
         stat_q  <= ST_OK;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               pc_q    <= pc_in;
               len_out <= len_in;
               stat_q  <= ST_OK;
               st      <= S_CHECK;
            end
            S_CHECK: begin
               if (dec.illegal) begin
                  stat_q <= ST_ILLEGAL;
                  st     <= S_DONE;
               end else if (dec.words == 2'd0) begin
                  stat_q <= end_stat;
                  st     <= S_DONE;
               end else begin
                  st <= S_W1;
               end
            end
            S_W1: if (fetch_valid) begin
               if (fetch_fault) begin
                  stat_q <= ST_FAULT;
                  st     <= S_DONE;
               end else begin
                  len_out <= len_out + STEP;
                  if (dec.words == 2'd2) begin
                     st <= S_W2;
                  end else begin
                     stat_q <= end_stat;
                     st     <= S_DONE;
                  end
               end
            end
            S_W2: if (fetch_valid) begin
               if (fetch_fault) begin
                  stat_q <= ST_FAULT;
               end else begin
                  len_out <= len_out + STEP;
                  stat_q  <= end_stat;
               end
               st <= S_DONE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/amd_ext_decoder.sv
module amd_ext_decoder
   import amd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 8,
   parameter int SIZE_W   = 4,
   parameter int IMM_W    = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [5:0]        modreg,
   input  logic [SIZE_W-1:0] op_size,
   input  logic [ADDR_W-1:0] pc,
   input  logic [LEN_W-1:0]  len_in,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_valid,
   input  logic              fetch_fault,
   input  logic [15:0]       fetch_data,
   output logic              done,
   output logic [1:0]        status,
   output logic [3:0]        reg_num,
   output logic [7:0]        flags,
   output logic [IMM_W-1:0]  immed,
   output logic [LEN_W-1:0]  ins_len
);
   generate
      if (IMM_W != 32) begin : g_bad_imm
         $error("amd_ext_decoder: IMM_W must be 32");
      end
      if (SIZE_W < 3) begin : g_bad_size
         $error("amd_ext_decoder: SIZE_W must hold sizes above 4");
      end
      if (LEN_W < 3 || LEN_W > ADDR_W) begin : g_bad_len
         $error("amd_ext_decoder: LEN_W out of range");
      end
   endgenerate

   logic [5:0]        modreg_q;
   logic [SIZE_W-1:0] size_q;
   amd_decode_t       dec;
   logic              accept;
   logic              take_first;
   logic              take_second;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modreg_q <= '0;
         size_q   <= '0;
      end else if (accept) begin
         modreg_q <= modreg;
         size_q   <= op_size;
      end
   end

   amd_mode_decode #(.SIZE_W(SIZE_W)) u_dec (
      .modreg  (modreg_q),
      .op_size (size_q),
      .dec     (dec)
   );

   amd_fetch_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .pc_in       (pc),
      .len_in      (len_in),
      .dec         (dec),
      .fetch_valid (fetch_valid),
      .fetch_fault (fetch_fault),
      .accept      (accept),
      .take_first  (take_first),
      .take_second (take_second),
      .fetch_req   (fetch_req),
      .fetch_addr  (fetch_addr),
      .done        (done),
      .status      (status),
      .len_out     (ins_len)
   );

   amd_ext_assembler #(.IMM_W(IMM_W), .SIGN_EXT(SIGN_EXT)) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .take_first  (take_first),
      .take_second (take_second),
      .word        (fetch_data),
      .imm         (immed)
   );

   assign reg_num = dec.regnum;
   assign flags   = dec.flags;
endmodule

// File: rtl/amd_ext_decoder_chk.sv
module amd_ext_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] pc,
   input logic [LEN_W-1:0]  len_in,
   input logic              fetch_req,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              fetch_valid,
   input logic              fetch_fault,
   input logic              done,
   input logic [1:0]        status,
   input logic [LEN_W-1:0]  ins_len
);
   logic              busy_c;
   logic [ADDR_W-1:0] pc_c;
   logic [LEN_W-1:0]  base_c;
   logic [2:0]        cnt_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         pc_c   <= '0;
         base_c <= '0;
         cnt_c  <= '0;
      end else if (start && !busy_c) begin
         busy_c <= 1'b1;
         pc_c   <= pc;
         base_c <= len_in;
         cnt_c  <= '0;
      end else begin
         if (done) busy_c <= 1'b0;
         if (fetch_req && fetch_valid && !fetch_fault) cnt_c <= cnt_c + 3'd1;
      end
   end

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));

   p_fetch_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> (fetch_addr == pc_c + ADDR_W'(base_c) + ADDR_W'({cnt_c, 1'b0})));

   p_len_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ins_len == base_c + LEN_W'({cnt_c, 1'b0})));

   p_illegal_nofetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> (cnt_c == 3'd0));

   p_word_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_c <= 3'd2);

   p_no_req_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !fetch_req);
endmodule

bind amd_ext_decoder amd_ext_decoder_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .pc          (pc),
   .len_in      (len_in),
   .fetch_req   (fetch_req),
   .fetch_addr  (fetch_addr),
   .fetch_valid (fetch_valid),
   .fetch_fault (fetch_fault),
   .done        (done),
   .status      (status),
   .ins_len     (ins_len)
);

// File: tb/amd_ext_decoder_tb_top.sv
module amd_ext_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  modreg = '0;
   logic [3:0]  op_size = '0;
   logic [31:0] pc = '0;
   logic [7:0]  len_in = '0;
   logic        fetch_req;
   logic [31:0] fetch_addr;
   logic        fetch_valid = 1'b0;
   logic        fetch_fault = 1'b0;
   logic [15:0] fetch_data = '0;
   logic        done;
   logic [1:0]  status;
   logic [3:0]  reg_num;
   logic [7:0]  flags;
   logic [31:0] immed;
   logic [7:0]  ins_len;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [15:0] mem [0:15];
   int          lat = 1;
   bit          fault_en = 0;
   logic [31:0] fault_addr = '0;
   int          reads = 0;
   logic [31:0] addr_log [0:3];
   int          hold_err = 0;

   logic [1:0]  g_status;
   logic [3:0]  g_reg;
   logic [7:0]  g_flags;
   logic [31:0] g_imm;
   logic [7:0]  g_len;

   always #5 clk = ~clk;

   amd_ext_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .modreg(modreg), .op_size(op_size),
      .pc(pc), .len_in(len_in), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .fetch_fault(fetch_fault), .fetch_data(fetch_data),
      .done(done), .status(status), .reg_num(reg_num), .flags(flags),
      .immed(immed), .ins_len(ins_len)
   );

   // read port model: answers after lat waiting negedges
   initial begin
      int          wait_cnt;
      logic [31:0] prev_addr;
      wait_cnt = 0;
      prev_addr = '0;
      forever begin
         @(negedge clk);
         if (fetch_valid) begin
            fetch_valid = 1'b0;
            fetch_fault = 1'b0;
         end else if (fetch_req) begin
            if (wait_cnt > 0 && fetch_addr != prev_addr) hold_err++;
            prev_addr = fetch_addr;
            wait_cnt++;
            if (wait_cnt >= lat) begin
               if (reads < 4) addr_log[reads] = fetch_addr;
               reads++;
               fetch_valid = 1'b1;
               fetch_fault = fault_en && (fetch_addr == fault_addr);
               fetch_data  = mem[fetch_addr[4:1]];
               wait_cnt = 0;
            end
         end else if (wait_cnt > 0) begin
            hold_err++;
            wait_cnt = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [15:0] w);
      mem[a[4:1]] = w;
   endtask

   task automatic run(input logic [5:0] m, input logic [3:0] sz,
                      input logic [31:0] p, input logic [7:0] l);
      bit got;
      @(negedge clk);
      modreg = m; op_size = sz; pc = p; len_in = l; reads = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got = 0;
      for (int i = 0; i < 60 && !got; i++) begin
         if (done) begin
            got = 1;
            g_status = status; g_reg = reg_num; g_flags = flags;
            g_imm = immed; g_len = ins_len;
         end else begin
            @(negedge clk);
         end
      end
      chk(got, "R9 done timeout", 32'(got), 32'd1);
   endtask

   task automatic t_reset();
      chk(done == 1'b0, "R9 reset done", 32'(done), 0);
      chk(fetch_req == 1'b0, "R9 reset fetch_req", 32'(fetch_req), 0);
   endtask

   task automatic t_dreg_r1();
      run(6'o05, 4'd4, 32'h100, 8'd4);
      chk(g_reg == 4'd5, "R1 reg", 32'(g_reg), 5);
      chk(g_flags == 8'h01, "R1 flags", 32'(g_flags), 32'h01);
      chk(g_len == 8'd4 && reads == 0, "R1 len/reads", 32'(g_len), 4);
      chk(g_status == 2'd0, "R1 status", 32'(g_status), 0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
   endtask

   task automatic t_areg_r2();
      logic [7:0] exp_f [1:4];
      exp_f[1] = 8'h01; exp_f[2] = 8'h00; exp_f[3] = 8'h04; exp_f[4] = 8'h02;
      for (int md = 1; md <= 4; md++) begin
         run({3'(md), 3'd3}, 4'd4, 32'h200, 8'd4);
         chk(g_reg == 4'd11, "R2 reg", 32'(g_reg), 11);
         chk(g_flags == exp_f[md], "R2 flags", 32'(g_flags), 32'(exp_f[md]));
         chk(reads == 0 && g_len == 8'd4, "R2 no fetch", 32'(reads), 0);
      end
   endtask

   task automatic t_disp_r3();
      put(32'h104, 16'hFFF0);
      run(6'o52, 4'd4, 32'h100, 8'd4);
      chk(g_reg == 4'd10 && g_flags == 8'h08, "R3 mode5 desc", {g_reg, g_flags}, {4'd10, 8'h08});
      chk(g_imm == 32'hFFFF_FFF0, "R3 sign extend", g_imm, 32'hFFFF_FFF0);
      chk(g_len == 8'd6 && reads == 1, "R3 len", 32'(g_len), 6);
      chk(addr_log[0] == 32'h104, "R6 word address", addr_log[0], 32'h104);
      put(32'h104, 16'h1234);
      run(6'o67, 4'd4, 32'h100, 8'd4);
      chk(g_reg == 4'd15 && g_flags == 8'h10, "R3 mode6 desc", {g_reg, g_flags}, {4'd15, 8'h10});
      chk(g_imm == 32'h0000_1234, "R3 positive word", g_imm, 32'h1234);
   endtask

   task automatic t_mode7_r4();
      put(32'h106, 16'h8001);
      run(6'o70, 4'd4, 32'h100, 8'd6);
      chk(g_flags == 8'h20 && g_imm == 32'hFFFF_8001, "R4 abs short", g_imm, 32'hFFFF_8001);
      put(32'h106, 16'h8765); put(32'h108, 16'h4321);
      run(6'o71, 4'd4, 32'h100, 8'd6);
      chk(g_imm == 32'h8765_4321 && g_reg == 4'd1, "R4 abs long", g_imm, 32'h8765_4321);
      chk(g_len == 8'd10 && reads == 2, "R6 two words len", 32'(g_len), 10);
      chk(addr_log[1] == 32'h108, "R6 second address", addr_log[1], 32'h108);
      run(6'o72, 4'd4, 32'h100, 8'd6);
      chk(g_flags == 8'h48 && reads == 1, "R4 pc offset", 32'(g_flags), 32'h48);
      run(6'o73, 4'd4, 32'h100, 8'd6);
      chk(g_flags == 8'h50 && reads == 1, "R4 pc indexed", 32'(g_flags), 32'h50);
      run(6'o74, 4'd2, 32'h100, 8'd6);
      chk(g_flags == 8'h80 && reads == 1 && g_imm == 32'hFFFF_8765, "R4 imm word", g_imm, 32'hFFFF_8765);
      run(6'o74, 4'd4, 32'h100, 8'd6);
      chk(reads == 2 && g_imm == 32'h8765_4321 && g_status == 2'd0, "R4 imm long", g_imm, 32'h8765_4321);
      run(6'o74, 4'd0, 32'h100, 8'd6);
      chk(reads == 0 && g_len == 8'd6, "R4 imm zero size", 32'(reads), 0);
   endtask

   task automatic t_illegal_r5();
      for (int r = 5; r <= 7; r++) begin
         run({3'd7, 3'(r)}, 4'd4, 32'h100, 8'd4);
         chk(g_status == 2'd1, "R5 status", 32'(g_status), 1);
         chk(reads == 0 && g_len == 8'd4, "R5 no fetch", 32'(reads), 0);
      end
   endtask

   task automatic t_fault_r7();
      fault_en = 1; fault_addr = 32'h108;
      run(6'o71, 4'd4, 32'h100, 8'd6);
      chk(g_status == 2'd2, "R7 fault second", 32'(g_status), 2);
      chk(reads == 2 && g_len == 8'd8, "R7 len after fault", 32'(g_len), 8);
      fault_addr = 32'h106;
      run(6'o71, 4'd4, 32'h100, 8'd6);
      chk(g_status == 2'd2 && reads == 1, "R7 fault first aborts", 32'(reads), 1);
      chk(g_len == 8'd6, "R7 len unchanged", 32'(g_len), 6);
      fault_en = 0;
   endtask

   task automatic t_hold_r8();
      lat = 5; hold_err = 0;
      run(6'o71, 4'd4, 32'h100, 8'd6);
      chk(hold_err == 0, "R8 request held", 32'(hold_err), 0);
      chk(g_imm == 32'h8765_4321, "R8 data with latency", g_imm, 32'h8765_4321);
      lat = 1;
   endtask

   task automatic t_wide_r10();
      run(6'o74, 4'd12, 32'h100, 8'd6);
      chk(g_status == 2'd3, "R10 status", 32'(g_status), 3);
      chk(reads == 2 && g_len == 8'd10, "R10 two words only", 32'(reads), 2);
      chk(g_imm == 32'h8765_4321, "R10 packing", g_imm, 32'h8765_4321);
   endtask

   task automatic t_busy_r11();
      bit got;
      lat = 4;
      put(32'h104, 16'h0042);
      @(negedge clk);
      modreg = 6'o50; op_size = 4'd4; pc = 32'h100; len_in = 8'd4; reads = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk);
      modreg = 6'o05; len_in = 8'd20; start = 1'b1;
      @(negedge clk); start = 1'b0;
      got = 0;
      for (int i = 0; i < 60 && !got; i++) begin
         if (done) begin
            got = 1; g_reg = reg_num; g_flags = flags; g_len = ins_len; g_imm = immed;
         end else @(negedge clk);
      end
      chk(got && g_reg == 4'd8 && g_flags == 8'h08, "R11 descriptor kept", {g_reg, g_flags}, {4'd8, 8'h08});
      chk(g_len == 8'd6 && g_imm == 32'h42, "R11 length kept", 32'(g_len), 6);
      lat = 1;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_dreg_r1();
      t_areg_r2();
      t_disp_r3();
      t_mode7_r4();
      t_illegal_r5();
      t_fault_r7();
      t_hold_r8();
      t_wide_r10();
      t_busy_r11();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule